// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small, fully associative translation cache for a memory management path. It holds pairs of virtual page number and physical frame number. Each pair is tagged with the address-space identifier (ASID) of the process that owns it, so mappings from several processes can stay resident at the same time. Each lookup compares its page number and ASID against every entry at once. The result (hit with frame, miss, or protection fault) is presented one clock later on registered outputs.

On a miss, an external page-table walker fetches the mapping and writes it back through the refill port. The block picks the slot. A slot already holding the same key is reused. Otherwise an empty slot is used. Otherwise a victim is evicted, chosen by least-recently-used order or by a pseudo-random sequence, depending on a parameter. Entries marked wired are pinned and are never evicted. Entries marked global match every ASID. Two invalidation commands are provided: one clears the whole cache, and one clears only the unpinned, non-global entries of one ASID.

Top module: `asid_tlb`

## Requirements
- R1: While `rst` is high, and after it is released, every entry is invalid and `rsp_valid`, `rsp_miss`, `rsp_fault` and `rsp_pfn` are zero. After reset, the least-recent order runs from the highest index (least recent) to index 0.
- R2: A lookup is presented on `lk_valid`. In the next cycle `rsp_valid` is 1. If a valid entry has the same page number and the same ASID, and the access is allowed, `rsp_pfn` carries that entry's frame and both `rsp_miss` and `rsp_fault` are 0.
- R3: A non-global entry misses for a lookup with a different ASID. An entry refilled with `rf_global`=1 hits for any lookup ASID.
- R4: Permission bits and access codes share one encoding: bit 0 is read, bit 1 is write, bit 2 is execute. A hit whose access requests a bit the entry does not grant gives `rsp_fault`=1, `rsp_miss`=0 and `rsp_pfn`=0.
- R5: A lookup that matches no entry gives `rsp_miss`=1, `rsp_fault`=0 and `rsp_pfn`=0. A cycle without a lookup gives all response outputs 0 in the next cycle.
- R6: A refill overwrites the lowest-index valid entry whose page number equals `rf_vpn`, provided that entry is global, or the refill is global, or the ASIDs are equal. If no such entry exists, the refill uses the lowest-index invalid entry. The written entry is visible to lookups from the next cycle. A lookup in the same cycle as a refill sees the old contents.
- R7: In LRU mode, when every entry is valid and none matches, the refill evicts the least recently used non-wired entry. A lookup hit (including a faulting hit) and a refill write each make their entry the most recent. When both happen in one cycle, only the refilled entry is updated.
- R8: A wired entry is never evicted. A refill that finds no match, no invalid entry and no non-wired entry is discarded.
- R9: `flush_all` invalidates every entry, wired ones included. A refill in the same cycle is discarded.
- R10: `flush_asid_valid` invalidates every valid entry whose ASID equals `flush_asid` and which is neither wired nor global. A refill in the same cycle is discarded. When both flush commands are raised in one cycle, `flush_all` takes effect.
- R11: When several valid entries match a lookup, the lowest-index one supplies the frame and the permissions.
- R12: In pseudo-random mode, the victim is the first non-wired entry at or after a position taken from a free-running LFSR, wrapping around. A wired entry is never chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asid | input | ASID_W | Lookup address-space identifier |
| lk_acc | input | 3 | Access kind: bit0 read, bit1 write, bit2 execute |
| rf_valid | input | 1 | Refill write from the walker |
| rf_vpn | input | VPN_W | Refill page number |
| rf_asid | input | ASID_W | Refill ASID |
| rf_pfn | input | PFN_W | Refill frame number |
| rf_perm | input | 3 | Refill permissions, same encoding as lk_acc |
| rf_wired | input | 1 | Pin the refilled entry against eviction |
| rf_global | input | 1 | Refilled entry matches any ASID |
| flush_all | input | 1 | Invalidate every entry |
| flush_asid_valid | input | 1 | Invalidate unpinned non-global entries of one ASID |
| flush_asid | input | ASID_W | ASID for the selective flush |
| rsp_valid | output | 1 | Response for the lookup of the previous cycle |
| rsp_miss | output | 1 | No matching entry |
| rsp_fault | output | 1 | Matching entry forbids the access |
| rsp_pfn | output | PFN_W | Frame number on a permitted hit, else 0 |

## Verification
Lookups are run in several conditions: against an empty cache, against entries whose ASID differs, against global entries, and against read-only entries with write and execute accesses. These separate a key-compare error from a permission error. Refills are issued in sequences that reach each placement rule in turn: overwrite of a matching entry, first empty slot, LRU eviction after a chosen pattern of hits, and a discarded write when every slot is wired. Together these show whether the recency tracking and the pinning work. Both flush commands are tried against mixes of wired, global and per-ASID entries, including refills raised in the same cycle. A second instance in pseudo-random mode is run through a fill where only one slot can be evicted, so its outcome is fixed whatever the LFSR state.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [0:0] {
    REPL_LRU  = 1'b0,
    REPL_RAND = 1'b1
  } repl_e;

  localparam int PERM_W = 3;
  localparam logic [PERM_W-1:0] PERM_RD = 3'b001;
  localparam logic [PERM_W-1:0] PERM_WR = 3'b010;
  localparam logic [PERM_W-1:0] PERM_EX = 3'b100;

  // true when the access asks for a right the entry does not grant
  function automatic logic perm_denied(input logic [PERM_W-1:0] granted,
                                       input logic [PERM_W-1:0] asked);
    return (asked & ~granted) != '0;
  endfunction

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N      = 8,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8,
  localparam int IW    = $clog2(N)
) (
  input  logic [N-1:0]             ent_v,
  input  logic [N-1:0][VPN_W-1:0]  ent_vpn,
  input  logic [N-1:0][ASID_W-1:0] ent_asid,
  input  logic [N-1:0]             ent_glob,
  input  logic [VPN_W-1:0]         key_vpn,
  input  logic [ASID_W-1:0]        key_asid,
  input  logic                     key_any,
  output logic                     hit,
  output logic [IW-1:0]            idx
);

  logic [N-1:0] hit_vec;

  // one comparator per slot, all evaluated in parallel
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = ent_v[g] && (ent_vpn[g] == key_vpn) &&
                        (ent_glob[g] || key_any || (ent_asid[g] == key_asid));
  end

  assign hit = |hit_vec;

  // lowest index has priority
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/tlb_repl.sv
module tlb_repl #(
  parameter int            N    = 8,
  parameter tlb_pkg::repl_e REPL = tlb_pkg::REPL_LRU,
  localparam int           IW   = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          touch_en,
  input  logic [IW-1:0] touch_idx,
  input  logic [N-1:0]  ent_v,
  input  logic [N-1:0]  ent_wired,
  output logic          vic_ok,
  output logic [IW-1:0] vic_idx
);

  logic          free_found;
  logic [IW-1:0] free_idx;
  logic          pick_ok;
  logic [IW-1:0] pick_idx;

  // an empty slot always wins over eviction
  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!ent_v[i]) begin
        free_found = 1'b1;
        free_idx   = IW'(i);
      end
    end
  end

  if (REPL == tlb_pkg::REPL_LRU) begin : g_lru
    // age 0 = most recent; ages always form a permutation of 0..N-1
    logic [N-1:0][IW-1:0] age;

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int i = 0; i < N; i++) age[i] <= IW'(i);
      end else if (touch_en) begin
        for (int i = 0; i < N; i++) begin
          if (IW'(i) == touch_idx) begin
            age[i] <= '0;
          end else if (age[i] < age[touch_idx]) begin
            age[i] <= age[i] + 1'b1;
          end
        end
      end
    end

    always_comb begin
      logic [IW-1:0] best;
      pick_ok  = 1'b0;
      pick_idx = '0;
      best     = '0;
      for (int i = 0; i < N; i++) begin
        if (!ent_wired[i] && (!pick_ok || age[i] > best)) begin
          pick_ok  = 1'b1;
          pick_idx = IW'(i);
          best     = age[i];
        end
      end
    end

    // R7
    touched_youngest_chk: assert property (@(posedge clk) disable iff (rst)
      touch_en |=> (age[$past(touch_idx)] == '0));
  end else begin : g_rand
    logic [15:0] lfsr;

    always_ff @(posedge clk) begin
      if (rst) lfsr <= 16'hACE1;
      else     lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end

    always_comb begin
      int start_i;
      int j;
      pick_ok  = 1'b0;
      pick_idx = '0;
      start_i  = int'(lfsr) % N;
      for (int k = 0; k < N; k++) begin
        j = (start_i + k) % N;
        if (!pick_ok && !ent_wired[j]) begin
          pick_ok  = 1'b1;
          pick_idx = IW'(j);
        end
      end
    end

    logic unused_touch;
    assign unused_touch = touch_en ^ (^touch_idx);
  end

  assign vic_ok  = free_found | pick_ok;
  assign vic_idx = free_found ? free_idx : pick_idx;

  // R8
  victim_wired_chk: assert property (@(posedge clk) disable iff (rst)
    (vic_ok && &ent_v) |-> !ent_wired[vic_idx]);

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int             ENTRIES = 8,
  parameter int             VPN_W   = 20,
  parameter int             PFN_W   = 20,
  parameter int             ASID_W  = 8,
  parameter tlb_pkg::repl_e REPL    = tlb_pkg::REPL_LRU
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [2:0]        lk_acc,
  input  logic              rf_valid,
  input  logic [VPN_W-1:0]  rf_vpn,
  input  logic [ASID_W-1:0] rf_asid,
  input  logic [PFN_W-1:0]  rf_pfn,
  input  logic [2:0]        rf_perm,
  input  logic              rf_wired,
  input  logic              rf_global,
  input  logic              flush_all,
  input  logic              flush_asid_valid,
  input  logic [ASID_W-1:0] flush_asid,
  output logic              rsp_valid,
  output logic              rsp_miss,
  output logic              rsp_fault,
  output logic [PFN_W-1:0]  rsp_pfn
);

  localparam int IW = $clog2(ENTRIES);

  // tag and flag state
  logic [ENTRIES-1:0]             ent_v;
  logic [ENTRIES-1:0]             ent_wired;
  logic [ENTRIES-1:0]             ent_glob;
  logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn;
  logic [ENTRIES-1:0][ASID_W-1:0] ent_asid;
  // payload, written only on refill, no reset
  logic [PFN_W-1:0]               ent_pfn  [ENTRIES];
  logic [tlb_pkg::PERM_W-1:0]     ent_perm [ENTRIES];

  logic          lk_hit;
  logic [IW-1:0] lk_idx;
  logic          rf_hit;
  logic [IW-1:0] rf_idx;
  logic          vic_ok;
  logic [IW-1:0] vic_idx;
  logic          flush_any;
  logic          wr_en;
  logic [IW-1:0] wr_idx;
  logic          touch_en;
  logic [IW-1:0] touch_idx;
  logic          lk_deny;

  tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_match (
    .ent_v    (ent_v),
    .ent_vpn  (ent_vpn),
    .ent_asid (ent_asid),
    .ent_glob (ent_glob),
    .key_vpn  (lk_vpn),
    .key_asid (lk_asid),
    .key_any  (1'b0),
    .hit      (lk_hit),
    .idx      (lk_idx)
  );

  tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_rf_match (
    .ent_v    (ent_v),
    .ent_vpn  (ent_vpn),
    .ent_asid (ent_asid),
    .ent_glob (ent_glob),
    .key_vpn  (rf_vpn),
    .key_asid (rf_asid),
    .key_any  (rf_global),
    .hit      (rf_hit),
    .idx      (rf_idx)
  );

  tlb_repl #(.N(ENTRIES), .REPL(REPL)) u_repl (
    .clk       (clk),
    .rst       (rst),
    .touch_en  (touch_en),
    .touch_idx (touch_idx),
    .ent_v     (ent_v),
    .ent_wired (ent_wired),
    .vic_ok    (vic_ok),
    .vic_idx   (vic_idx)
  );

  assign flush_any = flush_all | flush_asid_valid;
  assign wr_en     = rf_valid && !flush_any && (rf_hit || vic_ok);
  assign wr_idx    = rf_hit ? rf_idx : vic_idx;

  // a refill write outranks the lookup hit for recency
  assign touch_en  = wr_en || (lk_valid && lk_hit);
  assign touch_idx = wr_en ? wr_idx : lk_idx;

  assign lk_deny = tlb_pkg::perm_denied(ent_perm[lk_idx], lk_acc);

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_v     <= '0;
      ent_wired <= '0;
      ent_glob  <= '0;
      ent_vpn   <= '0;
      ent_asid  <= '0;
    end else if (flush_all) begin
      ent_v <= '0;
    end else if (flush_asid_valid) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (!ent_wired[i] && !ent_glob[i] && ent_asid[i] == flush_asid) ent_v[i] <= 1'b0;
      end
    end else if (wr_en) begin
      ent_v[wr_idx]     <= 1'b1;
      ent_wired[wr_idx] <= rf_wired;
      ent_glob[wr_idx]  <= rf_global;
      ent_vpn[wr_idx]   <= rf_vpn;
      ent_asid[wr_idx]  <= rf_asid;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      ent_pfn[wr_idx]  <= rf_pfn;
      ent_perm[wr_idx] <= rf_perm;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_pfn   <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_miss  <= lk_valid && !lk_hit;
      rsp_fault <= lk_valid && lk_hit && lk_deny;
      rsp_pfn   <= (lk_valid && lk_hit && !lk_deny) ? ent_pfn[lk_idx] : '0;
    end
  end

  // R2
  rsp_follow_chk: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid);

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> (!rsp_valid && !rsp_miss && !rsp_fault && rsp_pfn == '0));

  // R4
  miss_fault_excl_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !(rsp_miss && rsp_fault));

  // R5
  pfn_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_miss || rsp_fault) |-> (rsp_pfn == '0));

  // R9
  flush_miss_chk: assert property (@(posedge clk) disable iff (rst)
    flush_all ##1 lk_valid |=> rsp_miss);

  // R10
  wired_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !flush_all |=> ((ent_v & $past(ent_v & ent_wired)) == $past(ent_v & ent_wired)));

endmodule

// File: tb/tb_asid_tlb.sv
module tb_asid_tlb;
  localparam int N  = 4;
  localparam int VW = 12;
  localparam int PW = 12;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          lk_valid = 0, rf_valid = 0, rf_wired = 0, rf_global = 0;
  logic          flush_all = 0, flush_asid_valid = 0;
  logic [VW-1:0] lk_vpn = '0, rf_vpn = '0;
  logic [AW-1:0] lk_asid = '0, rf_asid = '0, flush_asid = '0;
  logic [2:0]    lk_acc = '0, rf_perm = '0;
  logic [PW-1:0] rf_pfn = '0;
  logic          rsp_valid, rsp_miss, rsp_fault;
  logic [PW-1:0] rsp_pfn;
  logic          r_valid, r_miss, r_fault;
  logic [PW-1:0] r_pfn;

  asid_tlb #(.ENTRIES(N), .VPN_W(VW), .PFN_W(PW), .ASID_W(AW), .REPL(tlb_pkg::REPL_LRU)) dut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
    .lk_acc(lk_acc), .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_asid(rf_asid),
    .rf_pfn(rf_pfn), .rf_perm(rf_perm), .rf_wired(rf_wired), .rf_global(rf_global),
    .flush_all(flush_all), .flush_asid_valid(flush_asid_valid), .flush_asid(flush_asid),
    .rsp_valid(rsp_valid), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault), .rsp_pfn(rsp_pfn));

  asid_tlb #(.ENTRIES(N), .VPN_W(VW), .PFN_W(PW), .ASID_W(AW), .REPL(tlb_pkg::REPL_RAND)) dut_rnd (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
    .lk_acc(lk_acc), .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_asid(rf_asid),
    .rf_pfn(rf_pfn), .rf_perm(rf_perm), .rf_wired(rf_wired), .rf_global(rf_global),
    .flush_all(flush_all), .flush_asid_valid(flush_asid_valid), .flush_asid(flush_asid),
    .rsp_valid(r_valid), .rsp_miss(r_miss), .rsp_fault(r_fault), .rsp_pfn(r_pfn));

  // behavioural reference state
  bit m_v[N];
  bit m_w[N];
  bit m_g[N];
  int m_vpn[N];
  int m_asid[N];
  int m_pfn[N];
  int m_perm[N];
  int lru_q[$];   // front = least recently used
  bit e_valid, e_miss, e_fault;
  int e_pfn;

  int    checks = 0;
  int    errors = 0;
  string phase  = "R1";
  bit    done   = 0;
  bit    chk_rnd = 0;

  function automatic void touch(int k);
    for (int q = 0; q < lru_q.size(); q++) begin
      if (lru_q[q] == k) begin
        lru_q.delete(q);
        break;
      end
    end
    lru_q.push_back(k);
  endfunction

  always @(posedge clk) begin : model
    int hidx;
    int widx;
    int hperm;
    bit wrote;
    if (rst) begin
      for (int i = 0; i < N; i++) m_v[i] = 0;
      lru_q.delete();
      for (int i = N - 1; i >= 0; i--) lru_q.push_back(i);
      e_valid = 0; e_miss = 0; e_fault = 0; e_pfn = 0;
    end else begin
      hidx = -1;
      for (int i = N - 1; i >= 0; i--)
        if (m_v[i] && m_vpn[i] == int'(lk_vpn) && (m_g[i] || m_asid[i] == int'(lk_asid))) hidx = i;
      hperm   = (hidx >= 0) ? m_perm[hidx] : 0;
      e_valid = lk_valid;
      e_miss  = lk_valid && (hidx < 0);
      e_fault = lk_valid && (hidx >= 0) && ((int'(lk_acc) & ~hperm) != 0);
      e_pfn   = (lk_valid && hidx >= 0 && !e_fault) ? m_pfn[hidx] : 0;
      wrote = 0;
      if (flush_all) begin
        for (int i = 0; i < N; i++) m_v[i] = 0;
      end else if (flush_asid_valid) begin
        for (int i = 0; i < N; i++)
          if (!m_w[i] && !m_g[i] && m_asid[i] == int'(flush_asid)) m_v[i] = 0;
      end else if (rf_valid) begin
        widx = -1;
        for (int i = N - 1; i >= 0; i--)
          if (m_v[i] && m_vpn[i] == int'(rf_vpn) &&
              (m_g[i] || rf_global || m_asid[i] == int'(rf_asid))) widx = i;
        if (widx < 0)
          for (int i = N - 1; i >= 0; i--) if (!m_v[i]) widx = i;
        if (widx < 0)
          for (int q = 0; q < lru_q.size(); q++)
            if (!m_w[lru_q[q]]) begin widx = lru_q[q]; break; end
        if (widx >= 0) begin
          m_v[widx] = 1; m_w[widx] = rf_wired; m_g[widx] = rf_global;
          m_vpn[widx] = int'(rf_vpn); m_asid[widx] = int'(rf_asid);
          m_pfn[widx] = int'(rf_pfn); m_perm[widx] = int'(rf_perm);
          touch(widx);
          wrote = 1;
        end
      end
      if (!wrote && lk_valid && hidx >= 0) touch(hidx);
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (rsp_valid !== e_valid || rsp_miss !== e_miss || rsp_fault !== e_fault ||
          rsp_pfn !== PW'(e_pfn)) begin
        errors++;
        $display("FAIL %s: got v=%0b m=%0b f=%0b pfn=%0h, expected v=%0b m=%0b f=%0b pfn=%0h",
                 phase, rsp_valid, rsp_miss, rsp_fault, rsp_pfn, e_valid, e_miss, e_fault, e_pfn);
      end
      if (chk_rnd) begin
        checks++;
        if (r_valid !== e_valid || r_miss !== e_miss || r_fault !== e_fault ||
            r_pfn !== PW'(e_pfn)) begin
          errors++;
          $display("FAIL R12 random mode: got v=%0b m=%0b f=%0b pfn=%0h, expected v=%0b m=%0b f=%0b pfn=%0h",
                   r_valid, r_miss, r_fault, r_pfn, e_valid, e_miss, e_fault, e_pfn);
        end
      end
    end
  end

  task automatic clr();
    lk_valid = 0; rf_valid = 0; flush_all = 0; flush_asid_valid = 0;
    rf_wired = 0; rf_global = 0;
  endtask

  task automatic go();
    @(negedge clk);
    clr();
  endtask

  task automatic set_rf(int vpn, int asid, int pfn, int perm, bit w, bit g);
    rf_valid = 1; rf_vpn = VW'(vpn); rf_asid = AW'(asid); rf_pfn = PW'(pfn);
    rf_perm = 3'(perm); rf_wired = w; rf_global = g;
  endtask

  task automatic set_lk(int vpn, int asid, int acc);
    lk_valid = 1; lk_vpn = VW'(vpn); lk_asid = AW'(asid); lk_acc = 3'(acc);
  endtask

  task automatic look(int vpn, int asid, int acc);
    set_lk(vpn, asid, acc);
    go();
  endtask

  task automatic refill(int vpn, int asid, int pfn, int perm, bit w, bit g);
    set_rf(vpn, asid, pfn, perm, w, g);
    go();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: empty after reset
    phase = "R1";
    go();
    look(12'h001, 1, 1);
    look(12'h010, 0, 4);
    // R2 and R6: refill, then hit; lookup alongside refill sees old contents
    phase = "R6";
    set_rf(12'h010, 1, 12'h0A1, 7, 0, 0);
    set_lk(12'h010, 1, 1);
    go();
    phase = "R2";
    look(12'h010, 1, 1);
    look(12'h010, 1, 2);
    // R3: ASID mismatch and global match
    phase = "R3";
    look(12'h010, 2, 1);
    refill(12'h020, 3, 12'h0C3, 7, 0, 1);
    look(12'h020, 5, 1);
    look(12'h020, 3, 4);
    // R4: read-only entry
    phase = "R4";
    refill(12'h030, 1, 12'h0D4, 1, 0, 0);
    look(12'h030, 1, 2);
    look(12'h030, 1, 4);
    look(12'h030, 1, 1);
    // R6: overwrite of matching entry, then pinned fill
    phase = "R6";
    refill(12'h010, 1, 12'h0B2, 3, 0, 0);
    look(12'h010, 1, 1);
    refill(12'h040, 1, 12'h0E5, 7, 1, 0);
    look(12'h040, 1, 1);
    // R7: recency-driven eviction
    phase = "R7";
    look(12'h020, 9, 1);
    look(12'h010, 1, 1);
    look(12'h030, 1, 2);       // faulting hit still refreshes
    refill(12'h050, 2, 12'h0F6, 7, 0, 0);
    look(12'h020, 9, 1);
    look(12'h010, 1, 1);
    set_rf(12'h060, 2, 12'h0A7, 7, 0, 0);
    set_lk(12'h030, 1, 1);
    go();
    for (int k = 0; k < 4; k++) look(12'h010 + 16 * k, 1 + k % 2, 1);
    look(12'h040, 1, 1);
    // R11: duplicates resolved by lowest index
    phase = "R11";
    refill(12'h060, 5, 12'h011, 7, 0, 0);
    refill(12'h060, 7, 12'h022, 7, 0, 1);
    look(12'h060, 2, 1);
    look(12'h060, 5, 1);
    look(12'h060, 7, 1);
    // R10: selective flush keeps wired and global
    phase = "R10";
    flush_asid_valid = 1; flush_asid = 4'd1;
    set_rf(12'h070, 1, 12'h033, 7, 0, 0);
    go();
    look(12'h040, 1, 1);
    look(12'h070, 1, 1);
    look(12'h010, 1, 1);
    look(12'h060, 3, 1);
    flush_asid_valid = 1; flush_asid = 4'd5;
    go();
    for (int k = 0; k < 8; k++) look(12'h010 * (k % 8), k % 6, 1 << (k % 3));
    // R8: every slot wired, refill dropped
    phase = "R8";
    refill(12'h081, 4, 12'h041, 7, 1, 0);
    refill(12'h082, 4, 12'h042, 7, 1, 0);
    refill(12'h083, 4, 12'h043, 7, 1, 0);
    refill(12'h084, 4, 12'h044, 7, 1, 0);
    refill(12'h085, 4, 12'h045, 7, 0, 0);
    look(12'h085, 4, 1);
    for (int k = 0; k < 6; k++) look(12'h080 + k, 4, 1);
    flush_asid_valid = 1; flush_asid = 4'd4;
    go();
    look(12'h082, 4, 1);
    // R9: full flush clears wired too, refill in same cycle ignored
    phase = "R9";
    flush_all = 1;
    set_rf(12'h090, 4, 12'h055, 7, 0, 0);
    go();
    look(12'h082, 4, 1);
    look(12'h090, 4, 1);
    look(12'h020, 3, 1);
    // R12: random-mode instance, single evictable slot
    phase = "R12";
    flush_all = 1;
    go();
    chk_rnd = 1;
    refill(12'h0A0, 6, 12'h061, 7, 1, 0);
    refill(12'h0A1, 6, 12'h062, 7, 1, 0);
    refill(12'h0A2, 6, 12'h063, 7, 1, 0);
    refill(12'h0A3, 6, 12'h064, 7, 0, 0);
    refill(12'h0A4, 6, 12'h065, 7, 0, 0);
    look(12'h0A3, 6, 1);
    look(12'h0A4, 6, 1);
    look(12'h0A0, 6, 1);
    look(12'h0A2, 6, 4);
    go();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog (all requirements): got no end of run, expected end within 20000 cycles");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule